// File: doc/BRIEF.md
# Address Region Cache Attribute Matcher

This block decides, for every 32-bit access address, whether the access may be cached. Two programmable region registers each describe a set of 16 MB blocks through an 8-bit base and an 8-bit ignore mask, both compared against the top address byte. A separate global register holds the default attribute. The region registers are exceptions to that default: a matching enabled region supplies its own attribute. If both regions match, region 0 decides. This lets a small uncached window, for example a buffer shared with a DMA engine, sit inside a larger cached memory region.

Software programs the registers through a select/data/strobe write port. The memory pipeline presents an address with a valid strobe and gets back a registered attribute and the per-region hit flags one clock later. The cache arrays, tags, flushing and the bus protocol belong to other blocks.

Top module: `cache_attr_match`

## Requirements
- R1: With a zero mask, an enabled region matches exactly the 16 MB block whose address bits 31:24 equal its base, and no other address.
- R2: Mask bit k (write data bit 16+k) removes address bit 24+k from the compare. Setting the two lowest mask bits makes a 64 MB region, and setting the three lowest makes a 128 MB region.
- R3: A mask whose set bits are not contiguous from the low end yields several separate matching 16 MB blocks. Mask 0x90 with base 0x40 matches top bytes 0x40, 0x50, 0xC0 and 0xD0.
- R4: When no enabled region matches, the attribute equals the default mode. The default mode is bit 6 of the global register, which is written with select value 2.
- R5: When both regions match, the attribute comes from region 0 (select 0) and not from region 1 (select 1). Both hit flags are still reported.
- R6: A region whose enable bit (write data bit 15) is clear never reports a hit and never affects the attribute.
- R7: Register layout: bits 31:24 are the base, bits 23:16 the mask, bit 15 the enable and bit 6 the mode (1 = cacheable). Writes to any other bit have no effect. A write with select value 3 changes nothing.
- R8: A lookup presented while addrValid is high appears on the outputs after the next rising clock edge, with attrValid high. Lookups may follow back to back. In a cycle with no lookup, attrValid, regionHit and attrCacheable are all low.
- R9: A register write takes effect for lookups presented on later cycles. A lookup presented in the same cycle as the write uses the previous contents.
- R10: After reset, both regions are disabled and the default mode is uncached. Every lookup then reports no hit and uncached, and the outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Register select: 0 region 0, 1 region 1, 2 global, 3 none |
| regWrData | input | 32 | Register write data |
| regWrEn | input | 1 | Register write strobe |
| addr | input | 32 | Access address to classify |
| addrValid | input | 1 | Lookup request for addr |
| attrValid | output | 1 | Registered result is valid |
| attrCacheable | output | 1 | Resolved attribute, 1 = cacheable |
| regionHit | output | 2 | Per-region hit flags for the lookup |

## Verification
The checker runs on every cycle. It checks that each lookup yields exactly one valid result one clock later and that idle cycles drive quiet outputs. It also checks that a hit only comes from a region whose shadowed enable was set, that a miss returns the shadowed default mode, and that a region 0 hit returns region 0's shadowed mode. The checker does not decode addresses, so only the bench scenarios show the masked compare itself: exact 16 MB matching, 64 and 128 MB masks, scattered non-contiguous blocks, ignored register bits and selects, and the write-versus-lookup ordering within one cycle.

// File: rtl/cache_attr_pkg.sv
package cache_attr_pkg;

  localparam int DATA_W   = 32;
  localparam int TAG_W    = 8;
  localparam int BASE_LSB = 24;
  localparam int MASK_LSB = 16;
  localparam int EN_BIT   = 15;
  localparam int MODE_BIT = 6;
  localparam int IDX_W    = 4;

  typedef struct packed {
    logic [TAG_W-1:0] base;
    logic [TAG_W-1:0] mask;
    logic             enable;
    logic             cacheable;
  } region_cfg_t;

  typedef struct packed {
    logic             wrRegion;
    logic             wrGlobal;
    logic             lookup;
    logic [IDX_W-1:0] regIdx;
  } ctrl_strobe_t;

  function automatic region_cfg_t decodeRegion(input logic [DATA_W-1:0] d);
    region_cfg_t c;
    c.base      = d[BASE_LSB +: TAG_W];
    c.mask      = d[MASK_LSB +: TAG_W];
    c.enable    = d[EN_BIT];
    c.cacheable = d[MODE_BIT];
    return c;
  endfunction

endpackage

// File: rtl/cache_attr_ctrl.sv
module cache_attr_ctrl
  import cache_attr_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int SEL_W       = 2
) (
  input  logic [SEL_W-1:0] regSel,
  input  logic             regWrEn,
  input  logic             addrValid,
  output ctrl_strobe_t     strobe
);

  localparam logic [SEL_W-1:0] GLOBAL_SEL = SEL_W'(NUM_REGIONS);

  always_comb begin
    strobe        = '0;
    strobe.lookup = addrValid;
    strobe.regIdx = IDX_W'(regSel);
    if (regWrEn) begin
      if (regSel < GLOBAL_SEL) begin
        strobe.wrRegion = 1'b1;
      end else if (regSel == GLOBAL_SEL) begin
        strobe.wrGlobal = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cache_attr_dp.sv
module cache_attr_dp
  import cache_attr_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int ADDR_W      = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrl_strobe_t           strobe,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [ADDR_W-1:0]      addr,
  output logic                   attrValid,
  output logic                   attrCacheable,
  output logic [NUM_REGIONS-1:0] regionHit
);

  logic [TAG_W-1:0]       topByte;
  logic [NUM_REGIONS-1:0] hitVec;
  logic [NUM_REGIONS-1:0] modeVec;
  logic                   defaultCacheable;
  logic                   pickCacheable;
  logic                   unusedBits;

  assign topByte    = addr[ADDR_W-1 -: TAG_W];
  assign unusedBits = ^{addr[ADDR_W-TAG_W-1:0], wrData};

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : gRegion
    region_cfg_t cfgQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cfgQ <= '0;
      end else if (strobe.wrRegion && strobe.regIdx == IDX_W'(r)) begin
        cfgQ <= decodeRegion(wrData);
      end
    end

    assign hitVec[r]  = cfgQ.enable && (((topByte ^ cfgQ.base) & ~cfgQ.mask) == '0);
    assign modeVec[r] = cfgQ.cacheable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      defaultCacheable <= 1'b0;
    end else if (strobe.wrGlobal) begin
      defaultCacheable <= wrData[MODE_BIT];
    end
  end

  // Lowest-numbered hit overrides: scan from the top down.
  always_comb begin
    pickCacheable = defaultCacheable;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (hitVec[i]) pickCacheable = modeVec[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attrValid     <= 1'b0;
      attrCacheable <= 1'b0;
      regionHit     <= '0;
    end else begin
      attrValid     <= strobe.lookup;
      attrCacheable <= strobe.lookup ? pickCacheable : 1'b0;
      regionHit     <= strobe.lookup ? hitVec : '0;
    end
  end

endmodule

// File: rtl/cache_attr_match.sv
module cache_attr_match
  import cache_attr_pkg::*;
#(
  parameter  int NUM_REGIONS = 2,
  parameter  int ADDR_W      = 32,
  localparam int SEL_W       = $clog2(NUM_REGIONS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [SEL_W-1:0]       regSel,
  input  logic [DATA_W-1:0]      regWrData,
  input  logic                   regWrEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   addrValid,
  output logic                   attrValid,
  output logic                   attrCacheable,
  output logic [NUM_REGIONS-1:0] regionHit
);

  ctrl_strobe_t strobe;

  cache_attr_ctrl #(.NUM_REGIONS(NUM_REGIONS), .SEL_W(SEL_W)) uCtrl (
    .regSel    (regSel),
    .regWrEn   (regWrEn),
    .addrValid (addrValid),
    .strobe    (strobe)
  );

  cache_attr_dp #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .wrData        (regWrData),
    .addr          (addr),
    .attrValid     (attrValid),
    .attrCacheable (attrCacheable),
    .regionHit     (regionHit)
  );

endmodule

// File: rtl/cache_attr_match_chk.sv
module cache_attr_match_chk
  import cache_attr_pkg::*;
#(
  parameter int NUM_REGIONS = 2,
  parameter int SEL_W       = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [SEL_W-1:0]       regSel,
  input logic [DATA_W-1:0]      regWrData,
  input logic                   regWrEn,
  input logic                   addrValid,
  input logic                   attrValid,
  input logic                   attrCacheable,
  input logic [NUM_REGIONS-1:0] regionHit
);

  logic [NUM_REGIONS-1:0] enShadow;
  logic                   mode0Shadow;
  logic                   defShadow;
  logic                   unusedChk;

  assign unusedChk = ^regWrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enShadow    <= '0;
      mode0Shadow <= 1'b0;
      defShadow   <= 1'b0;
    end else if (regWrEn) begin
      for (int k = 0; k < NUM_REGIONS; k++) begin
        if (regSel == SEL_W'(k)) enShadow[k] <= regWrData[EN_BIT];
      end
      if (regSel == '0) mode0Shadow <= regWrData[MODE_BIT];
      if (regSel == SEL_W'(NUM_REGIONS)) defShadow <= regWrData[MODE_BIT];
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |=> attrValid);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |=> (!attrValid && regionHit == '0 && !attrCacheable));

  for (genvar k = 0; k < NUM_REGIONS; k++) begin : gEnChk
    a_r6_hit_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
      regionHit[k] |-> $past(enShadow[k]));
  end

  a_r4_default_on_miss: assert property (@(posedge clk) disable iff (!rstN)
    (attrValid && regionHit == '0) |-> attrCacheable == $past(defShadow));

  a_r5_region0_wins: assert property (@(posedge clk) disable iff (!rstN)
    (attrValid && regionHit[0]) |-> attrCacheable == $past(mode0Shadow));

endmodule

bind cache_attr_match cache_attr_match_chk #(.NUM_REGIONS(NUM_REGIONS), .SEL_W(SEL_W)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .regSel        (regSel),
  .regWrData     (regWrData),
  .regWrEn       (regWrEn),
  .addrValid     (addrValid),
  .attrValid     (attrValid),
  .attrCacheable (attrCacheable),
  .regionHit     (regionHit)
);

// File: tb/cache_attr_match_test.sv
module cache_attr_match_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = '0;
  logic [31:0] regWrData = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] addr = '0;
  logic        addrValid = 1'b0;
  logic        attrValid;
  logic        attrCacheable;
  logic [1:0]  regionHit;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] a;
    logic [1:0]  hit;
    logic        cache;
    string       tag;
  } exp_t;

  exp_t expQ[$];

  always #10 clk = ~clk;

  cache_attr_match uut (
    .clk           (clk),
    .rstN          (rstN),
    .regSel        (regSel),
    .regWrData     (regWrData),
    .regWrEn       (regWrEn),
    .addr          (addr),
    .addrValid     (addrValid),
    .attrValid     (attrValid),
    .attrCacheable (attrCacheable),
    .regionHit     (regionHit)
  );

  // Monitor: pops one expectation per valid result.
  always @(posedge clk) begin
    #2;
    if (rstN && attrValid) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL unexpected result hit=%b cache=%b expected none", regionHit, attrCacheable);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (regionHit !== e.hit || attrCacheable !== e.cache) begin
          failures++;
          $display("FAIL %s addr=%h hit=%b cache=%b expected hit=%b cache=%b",
                   e.tag, e.a, regionHit, attrCacheable, e.hit, e.cache);
        end
      end
    end
  end

  task automatic writeReg(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    regSel = s; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic pushExp(input logic [31:0] a, input logic [1:0] h, input logic c, input string t);
    exp_t e;
    e.a = a; e.hit = h; e.cache = c; e.tag = t;
    expQ.push_back(e);
  endtask

  task automatic lookup(input logic [31:0] a, input logic [1:0] h, input logic c, input string t);
    @(negedge clk);
    addr = a; addrValid = 1'b1;
    pushExp(a, h, c, t);
    @(negedge clk);
    addrValid = 1'b0;
  endtask

  task automatic checkIdle(input string t);
    checks++;
    if (attrValid !== 1'b0 || regionHit !== 2'b00 || attrCacheable !== 1'b0) begin
      failures++;
      $display("FAIL %s valid=%b hit=%b cache=%b expected 0 00 0", t, attrValid, regionHit, attrCacheable);
    end
  endtask

  task automatic finishRun();
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R8 missing results: %0d pending expected 0", expQ.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R10 outputs in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R10 outputs after reset");
    lookup(32'h4000_0000, 2'b00, 1'b0, "R10 uncached after reset");

    // R4: default mode from global register bit 6
    writeReg(2'd2, 32'h0000_0040);
    lookup(32'h4000_0000, 2'b00, 1'b1, "R4 default cacheable");
    writeReg(2'd2, 32'h0000_0000);
    lookup(32'h4000_0000, 2'b00, 1'b0, "R4 default uncached");

    // R1: zero mask, 16 MB exact
    writeReg(2'd1, 32'h4000_8040);
    lookup(32'h40FF_FFFF, 2'b10, 1'b1, "R1 inside top edge");
    lookup(32'h4000_0000, 2'b10, 1'b1, "R1 inside bottom edge");
    lookup(32'h4100_0000, 2'b00, 1'b0, "R1 just above");
    lookup(32'h3FFF_FFFC, 2'b00, 1'b0, "R1 just below");

    // R2: contiguous low masks
    writeReg(2'd1, 32'h4003_8040);
    lookup(32'h4300_0000, 2'b10, 1'b1, "R2 64MB last block");
    lookup(32'h4400_0000, 2'b00, 1'b0, "R2 64MB beyond");
    writeReg(2'd1, 32'h4007_8040);
    lookup(32'h4700_0010, 2'b10, 1'b1, "R2 128MB last block");
    lookup(32'h4800_0000, 2'b00, 1'b0, "R2 128MB beyond");

    // R3: non-contiguous mask 0x90
    writeReg(2'd1, 32'h4090_8040);
    lookup(32'h4000_0000, 2'b10, 1'b1, "R3 block 0x40");
    lookup(32'h5000_0000, 2'b10, 1'b1, "R3 block 0x50");
    lookup(32'hC000_0000, 2'b10, 1'b1, "R3 block 0xC0");
    lookup(32'hD0AB_CDEF, 2'b10, 1'b1, "R3 block 0xD0");
    lookup(32'h6000_0000, 2'b00, 1'b0, "R3 gap 0x60");
    lookup(32'h4100_0000, 2'b00, 1'b0, "R3 gap 0x41");

    // R5: overlap, region 0 wins
    writeReg(2'd1, 32'h4007_8040);
    writeReg(2'd0, 32'h4200_8000);
    lookup(32'h4200_1000, 2'b11, 1'b0, "R5 uncached window in cached region");
    lookup(32'h4100_0000, 2'b10, 1'b1, "R5 outside window");
    writeReg(2'd0, 32'h4200_8040);
    writeReg(2'd1, 32'h4007_8000);
    lookup(32'h4200_0000, 2'b11, 1'b1, "R5 cached window in uncached region");
    lookup(32'h4500_0000, 2'b10, 1'b0, "R5 outside window reversed");

    // R6: disabled regions
    writeReg(2'd0, 32'h4200_0040);
    lookup(32'h4200_0000, 2'b10, 1'b0, "R6 region0 disabled");
    writeReg(2'd2, 32'h0000_0040);
    writeReg(2'd1, 32'h4007_0040);
    lookup(32'h4200_0000, 2'b00, 1'b1, "R6 both disabled gives default");

    // R7: other bits ignored, select 3 ignored
    writeReg(2'd0, 32'h8000_FFBF);
    lookup(32'h8000_0000, 2'b01, 1'b0, "R7 junk bits do not set mode");
    lookup(32'h8100_0000, 2'b00, 1'b1, "R7 junk bits do not widen");
    writeReg(2'd3, 32'hFFFF_FFFF);
    lookup(32'h8000_0000, 2'b01, 1'b0, "R7 select 3 leaves region0");
    lookup(32'h4200_0000, 2'b00, 1'b1, "R7 select 3 leaves region1 and default");
    writeReg(2'd2, 32'hFFFF_FFBF);
    lookup(32'h1000_0000, 2'b00, 1'b0, "R7 global junk bits ignored");

    // R9: same-cycle write and lookup sees old contents
    @(negedge clk);
    regSel = 2'd0; regWrData = 32'h1000_8040; regWrEn = 1'b1;
    addr = 32'h1000_0000; addrValid = 1'b1;
    pushExp(32'h1000_0000, 2'b00, 1'b0, "R9 same cycle uses old");
    @(negedge clk);
    regWrEn = 1'b0;
    pushExp(32'h1000_0000, 2'b01, 1'b1, "R9 next cycle uses new");
    @(negedge clk);
    addrValid = 1'b0;

    // R8: back-to-back lookups, then idle
    @(negedge clk);
    addr = 32'h1000_0000; addrValid = 1'b1;
    pushExp(32'h1000_0000, 2'b01, 1'b1, "R8 back to back first");
    @(negedge clk);
    addr = 32'h2000_0000;
    pushExp(32'h2000_0000, 2'b00, 1'b0, "R8 back to back second");
    @(negedge clk);
    addrValid = 1'b0;
    @(negedge clk);
    checkIdle("R8 idle outputs quiet");

    repeat (2) @(negedge clk);
    done = 1'b1;
    finishRun();
  end

endmodule